// File: doc/BRIEF.md
# Key-Protected Event Flag Controller

This block gathers hardware event pulses into a small set of pending flags and raises one interrupt line. Each flag can be set by its hardware event input. Software can also force a flag pending through a write-one-to-set register, or drop it through a write-one-to-clear register. The interrupt output is the OR of all pending flags that are enabled.

Writes to the enable, set and clear registers take effect only while the block is unlocked. Software unlocks the block by writing a 16-bit key value to the key register. The bus is minimal: a byte offset, write data, a write strobe, and combinational read data. The oscillators and fault detectors that produce the events are outside this block and appear only as event inputs.

Top module: `evflag_ctrl`

## Requirements
- R1: After reset the enable and flag registers are zero, the block is locked, and `irq` is 0.
- R2: A write to offset 0x00 whose low 16 bits are 0x695A unlocks the block; the upper 16 bits of that write are ignored. A write to 0x00 with any other low half locks the block.
- R3: While the block is locked, writes to offsets 0x40 (enable), 0x50 (clear) and 0x58 (set) are dropped and change nothing.
- R4: Only flag bits 0, 1, 2, 6, 8, 9, 10, 12, 13, 14 and 15 exist (mask 0xF747). A high `hw_evt` bit at one of these positions sets that flag at the next clock edge. All other bit positions always read as zero, in both the flag and the enable registers.
- R5: A write to offset 0x50 clears each flag whose data bit is 1. A data bit of 0 leaves its flag unchanged.
- R6: A write to offset 0x58 sets each flag whose data bit is 1. A data bit of 0 leaves its flag unchanged.
- R7: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: `irq` is registered. It equals the OR of (flags AND enable) as they stood one cycle earlier.
- R9: Reads return the enable register at 0x40 and the flag register at 0x48, in bits 15:0. Reads at 0x00, 0x50, 0x58 and every other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 7 | Byte offset of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 32 | Read data for `addr` (combinational) |
| hw_evt | input | 16 | Hardware event inputs, one per flag position |
| irq | output | 1 | Interrupt request, registered |

## Verification
The bench walks every one of the 16 flag positions in three ways: by a hardware event, by a software set, and under a single-bit enable. This separates the eleven implemented bits from the five absent ones, and shows that each enable bit gates only its own flag. Clear writes are tried with all-zero data, with partial masks, and in the same cycle as a hardware event, which tells write-one-to-clear apart from plain overwrite and shows the hardware priority. Write attempts before unlocking, after a wrong key, and with a key that carries nonzero upper bits show that the lock gate depends only on the low 16 bits of the key.

// File: rtl/evflag_ctrl.sv
module evflag_ctrl #(
  parameter int          ADDR_W     = 7,
  parameter int          DATA_W     = 32,
  parameter int          NFLAG      = 16,
  parameter logic [15:0] UNLOCK_KEY = 16'h695A,
  parameter logic [15:0] FLAG_MASK  = 16'hF747,
  parameter logic [6:0]  OFF_KEY    = 7'h00,
  parameter logic [6:0]  OFF_EN     = 7'h40,
  parameter logic [6:0]  OFF_FLG    = 7'h48,
  parameter logic [6:0]  OFF_CLR    = 7'h50,
  parameter logic [6:0]  OFF_SET    = 7'h58
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [NFLAG-1:0]  hw_evt,
  output logic              irq
);
  localparam int PAD_W = DATA_W - NFLAG;
  localparam logic [NFLAG-1:0] MASK = FLAG_MASK[NFLAG-1:0];

  logic             open_q;
  logic [NFLAG-1:0] en_q, flg_q, flg_d, clr_v, set_v, evt_m;
  logic             ctl_wr;

  assign ctl_wr = wr_en && open_q;
  assign clr_v  = (ctl_wr && addr == OFF_CLR) ? wdata[NFLAG-1:0] : '0;
  assign set_v  = (ctl_wr && addr == OFF_SET) ? wdata[NFLAG-1:0] : '0;
  assign evt_m  = hw_evt & MASK;
  assign flg_d  = ((flg_q & ~clr_v) | set_v | evt_m) & MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      en_q   <= '0;
      flg_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en && addr == OFF_KEY)
        open_q <= (wdata[15:0] == UNLOCK_KEY);
      if (ctl_wr && addr == OFF_EN)
        en_q <= wdata[NFLAG-1:0] & MASK;
      flg_q <= flg_d;
      irq   <= |(flg_q & en_q);
    end
  end

  always_comb begin
    case (addr)
      OFF_EN:  rdata = {{PAD_W{1'b0}}, en_q};
      OFF_FLG: rdata = {{PAD_W{1'b0}}, flg_q};
      default: rdata = '0;
    endcase
  end

  assert_locked_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && wr_en && addr == OFF_EN) |=> $stable(en_q));

  assert_bad_key_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_KEY && wdata[15:0] != UNLOCK_KEY) |=> !open_q);

  assert_hw_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_m) |=> ((flg_q & $past(evt_m)) == $past(evt_m)));

  assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && wr_en && addr == OFF_CLR) |=>
      ((flg_q & $past(wdata[NFLAG-1:0]) & ~$past(evt_m)) == '0));

  assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == |($past(flg_q) & $past(en_q))));
endmodule

// File: tb/sim_evflag_ctrl.sv
`timescale 1ns/1ps
module sim_evflag_ctrl;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [6:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] hw_evt = 0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;
  localparam logic [15:0] M = 16'hF747;

  always #2 clk = ~clk;

  evflag_ctrl u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                  .wr_en(wr_en), .rdata(rdata), .hw_evt(hw_evt), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] v);
    addr = a; #0.5; v = rdata;
  endtask

  task automatic pulse(logic [15:0] e);
    @(negedge clk); hw_evt = e;
    @(negedge clk); hw_evt = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(7'h40, v); chk("R1 enable reset", v, 0);
    rd(7'h48, v); chk("R1 flags reset", v, 0);
    chk("R1 irq reset", {31'b0, irq}, 0);

    wr(7'h40, 32'hFFFF); rd(7'h40, v); chk("R3 locked enable write", v, 0);
    wr(7'h58, 32'hFFFF); rd(7'h48, v); chk("R3 locked set write", v, 0);

    wr(7'h00, 32'hABCD_695A);
    wr(7'h40, 32'hFFFF_FFFF); rd(7'h40, v); chk("R2 unlock upper ignored / R4 enable mask", v, {16'b0, M});

    for (int i = 0; i < 16; i++) begin
      logic [15:0] b = 16'(1) << i;
      pulse(b);
      rd(7'h48, v); chk("R4 hw event sweep", v, {16'b0, b & M});
      @(negedge clk);
      chk("R8 irq from hw sweep", {31'b0, irq}, {31'b0, |(b & M)});
      wr(7'h50, {16'b0, b}); rd(7'h48, v); chk("R5 clear sweep", v, 0);
    end

    for (int i = 0; i < 16; i++) begin
      logic [15:0] b = 16'(1) << i;
      wr(7'h58, {16'hFFFF, b}); rd(7'h48, v); chk("R6 set sweep", v, {16'b0, b & M});
      wr(7'h50, 32'hFFFF);
    end

    wr(7'h58, 32'hFFFF); rd(7'h48, v); chk("R6 set all", v, {16'b0, M});
    wr(7'h50, 32'h0);    rd(7'h48, v); chk("R5 clear zero no effect", v, {16'b0, M});
    wr(7'h50, 32'h00F0); rd(7'h48, v); chk("R5 partial clear", v, {16'b0, M & ~16'h00F0});

    for (int i = 0; i < 16; i++) begin
      logic [15:0] b = 16'(1) << i;
      wr(7'h40, {16'b0, b});
      @(negedge clk);
      chk("R8 single enable sweep", {31'b0, irq}, {31'b0, |(b & M & ~16'h00F0)});
    end

    wr(7'h40, 0); wr(7'h50, 32'hFFFF); @(negedge clk);
    wr(7'h58, 32'h0001);
    chk("R8 irq low while disabled", {31'b0, irq}, 0);
    wr(7'h40, 32'h0001);
    chk("R8 irq one cycle late", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R8 irq rises", {31'b0, irq}, 1);

    wr(7'h58, 32'h1000);
    @(negedge clk); addr = 7'h50; wdata = 32'h1001; wr_en = 1; hw_evt = 16'h1000;
    @(negedge clk); wr_en = 0; hw_evt = 0;
    rd(7'h48, v); chk("R7 hw beats clear", v, 32'h1000);

    wr(7'h00, 32'h0000_1234);
    wr(7'h50, 32'hFFFF); rd(7'h48, v); chk("R2 bad key relocks (R3 clear dropped)", v, 32'h1000);
    wr(7'h40, 32'hF000); rd(7'h40, v); chk("R3 enable held after relock", v, 32'h0001);
    wr(7'h00, 32'h695A_0000);
    wr(7'h40, 32'hF000); rd(7'h40, v); chk("R2 key in upper half does not unlock", v, 32'h0001);

    rd(7'h00, v); chk("R9 key reads zero", v, 0);
    rd(7'h50, v); chk("R9 clear reads zero", v, 0);
    rd(7'h58, v); chk("R9 set reads zero", v, 0);
    rd(7'h04, v); chk("R9 unmapped reads zero", v, 0);
    rd(7'h7C, v); chk("R9 unmapped top reads zero", v, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule